// File: doc/BRIEF.md
# Mixed-Signal Pin Port

This block manages a small port of pins that can each serve as an analog input for a converter or as a general-purpose digital pin. Three 8-bit registers set the port up. A mode register chooses analog or digital per pin. A direction register chooses input or output for digital pins. A data register sets the level driven on output pins. The block drives a per-pin output enable and output level toward the pads. It passes pad inputs through a two-flop synchroniser, and it gives the input multiplexer a per-pin flag that marks a pin as analog-only.

The registers are reached over a simple bus. A write takes effect at the clock edge where `wrEn` is high. A read request on `rdEn` returns its data on `rdData`, with `rdValid` high, one cycle later. A pin set to digital is not taken away from the converter's multiplexer. This lets a level the port drives be converted as a self-test. The `PIN_COUNT` parameter selects 4 or 8 active pins. Register bits above the active pins read as zero.

Top module: `mixed_io_port`

## Requirements
- R1: On reset the mode register holds all zeros, so every pin is analog. The direction register holds all ones, so every pin is an input. The data register holds zero. Every `padOe` bit is 0, every `analogSel` bit is 1, and `rdValid` is 0.
- R2: A pin whose mode bit is 0 is analog. Its `analogSel` bit is 1 and its `padOe` bit is 0, whatever its direction and data bits hold.
- R3: A pin whose mode bit is 1 is digital. Its `padOe` bit is 1 when its direction bit is 0 (output) and 0 when its direction bit is 1 (input). Its `analogSel` bit is 0.
- R4: `padOut` of an output pin equals its data-register bit (0 low, 1 high). `padOut` is 0 on any pin that is not driving.
- R5: Reading the data register (address 2) returns the pad input levels, delayed by two clock edges through the synchroniser, and not the value last written. Bits of analog pins read 0.
- R6: Address 0 reads back the mode register and address 1 reads back the direction register. Address 3 always reads 0, and a write to it changes nothing.
- R7: With `PIN_COUNT` = 4, only bits 3:0 of each register exist. Bits 7:4 of every read return 0.
- R8: Read data appears with `rdValid` high in the cycle after the `rdEn` request. A read issued in the same cycle as a write to the same address returns the value held before that write.
- R9: Direction and data bits written while a pin is analog are kept. They take effect as soon as the pin is switched to digital.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 mode, 1 direction, 2 data, 3 none |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read request |
| rdAddr | input | 2 | Read address, same map as writes |
| rdData | output | 8 | Read data, valid while rdValid is high |
| rdValid | output | 1 | High in the cycle after a read request |
| padIn | input | PIN_COUNT | Pad input levels, asynchronous to clk |
| padOe | output | PIN_COUNT | Per-pin output enable |
| padOut | output | PIN_COUNT | Per-pin output level |
| analogSel | output | PIN_COUNT | Per-pin flag: pin is analog-only |

## Verification
A register write and a read of the same register can fall in the same cycle. The bench issues both strobes together, with different data, on the mode, direction and data registers. The returned value is then judged against the model's value from before the write. A second collision comes from changing `padIn` in the same cycle that the data register is written and read. This shows that the readback follows the synchronised pins rather than the written bits. Both collisions are also provoked by random traffic in which every input changes on every cycle.

// File: rtl/mixio_pkg.sv
package mixio_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE = 2'd0,
    REG_DIR  = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    modeWe;
    logic    dirWe;
    logic    dataWe;
    logic    rdEn;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/mixio_sync.sv
module mixio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageA  <= '0;
      syncOut <= '0;
    end else begin
      stageA  <= asyncIn;
      syncOut <= stageA;
    end
  end
endmodule

// File: rtl/mixio_ctrl.sv
module mixio_ctrl
  import mixio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobes_t          stb
);
  always_comb begin
    stb.modeWe = wrEn && (regSel_e'(wrAddr) == REG_MODE);
    stb.dirWe  = wrEn && (regSel_e'(wrAddr) == REG_DIR);
    stb.dataWe = wrEn && (regSel_e'(wrAddr) == REG_DATA);
    stb.rdEn   = rdEn;
    stb.rdSel  = regSel_e'(rdAddr);
  end
endmodule

// File: rtl/mixio_dp.sv
module mixio_dp
  import mixio_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [BUS_W-1:0]     wrData,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] analogSel,
  output logic [BUS_W-1:0]     rdData,
  output logic                 rdValid
);
  localparam logic [PIN_COUNT-1:0] DIR_RESET = '1;

  logic [PIN_COUNT-1:0] modeReg;
  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] dataReg;
  logic [PIN_COUNT-1:0] padSync;
  logic [PIN_COUNT-1:0] pinView;
  logic [BUS_W-1:0]     rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      dirReg  <= DIR_RESET;
      dataReg <= '0;
    end else begin
      if (stb.modeWe) modeReg <= wrData[PIN_COUNT-1:0];
      if (stb.dirWe)  dirReg  <= wrData[PIN_COUNT-1:0];
      if (stb.dataWe) dataReg <= wrData[PIN_COUNT-1:0];
    end
  end

  mixio_sync #(.WIDTH(PIN_COUNT)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (padSync)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic isDigital;
    logic drives;
    assign isDigital    = modeReg[p];
    assign drives       = isDigital & ~dirReg[p];
    assign padOe[p]     = drives;
    assign padOut[p]    = drives & dataReg[p];
    assign analogSel[p] = ~isDigital;
    assign pinView[p]   = isDigital & padSync[p];
  end

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      REG_MODE: rdNext[PIN_COUNT-1:0] = modeReg;
      REG_DIR:  rdNext[PIN_COUNT-1:0] = dirReg;
      REG_DATA: rdNext[PIN_COUNT-1:0] = pinView;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/mixed_io_port.sv
module mixed_io_port
  import mixio_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 rdEn,
  input  logic [1:0]           rdAddr,
  output logic [7:0]           rdData,
  output logic                 rdValid,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] analogSel
);
  strobes_t stb;

  mixio_ctrl uCtrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  mixio_dp #(.PIN_COUNT(PIN_COUNT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .padIn     (padIn),
    .padOe     (padOe),
    .padOut    (padOut),
    .analogSel (analogSel),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );
endmodule

// File: rtl/mixio_checker.sv
module mixio_checker #(
  parameter int PIN_COUNT = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 rdEn,
  input logic [1:0]           rdAddr,
  input logic [7:0]           rdData,
  input logic                 rdValid,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] analogSel
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && analogSel == '1 && !rdValid));

  assert_analog_undriven_R2: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & analogSel) == '0);

  assert_quiet_when_undriven_R4: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & ~padOe) == '0);

  assert_read_returns_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_empty_slot_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd3) |=> (rdData == 8'h00));
endmodule

bind mixed_io_port mixio_checker #(.PIN_COUNT(PIN_COUNT)) uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .rdEn      (rdEn),
  .rdAddr    (rdAddr),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .padOe     (padOe),
  .padOut    (padOut),
  .analogSel (analogSel)
);

// File: tb/sim_mixed_io_port.sv
module sim_mixed_io_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, padIn = '0;

  logic [7:0] rdData0, rdData1;
  logic rdValid0, rdValid1;
  logic [7:0] padOe0, padOut0, analogSel0;
  logic [3:0] padOe1, padOut1, analogSel1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixed_io_port u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData0), .rdValid(rdValid0),
    .padIn(padIn), .padOe(padOe0), .padOut(padOut0), .analogSel(analogSel0));

  mixed_io_port #(.PIN_COUNT(4)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData1), .rdValid(rdValid1),
    .padIn(padIn[3:0]), .padOe(padOe1), .padOut(padOut1), .analogSel(analogSel1));

  int passCnt = 0;
  int failCnt = 0;
  bit started = 0;
  bit finished = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    if (act === exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] mMode = 8'h00, mDir = 8'hFF, mData = 8'h00, mRd = 8'h00;
  bit mRdV = 0, mInRst = 1;
  string mRdTag = "R6";
  logic [7:0] pinQ[$] = '{8'h00, 8'h00};

  function automatic logic [7:0] modelRead(logic [1:0] a);
    case (a)
      2'd0: return mMode;
      2'd1: return mDir;
      2'd2: return pinQ[0] & mMode;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 8'h00; mDir = 8'hFF; mData = 8'h00;
      pinQ = '{8'h00, 8'h00}; mRdV = 0; mInRst = 1;
    end else begin
      mInRst = 0;
      if (rdEn) begin
        mRd = modelRead(rdAddr);
        if (wrEn && wrAddr == rdAddr) mRdTag = "R8";
        else if (rdAddr == 2'd2) mRdTag = "R5";
        else mRdTag = "R6";
      end
      mRdV = rdEn;
      pinQ.push_back(padIn);
      void'(pinQ.pop_front());
      if (wrEn) begin
        case (wrAddr)
          2'd0: mMode = wrData;
          2'd1: mDir = wrData;
          2'd2: mData = wrData;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      logic [7:0] eOe, eOut;
      eOe  = mMode & ~mDir;
      eOut = eOe & mData;
      check(mInRst ? "R1 padOe" : "R3 padOe", padOe0, eOe);
      check(mInRst ? "R1 padOut" : "R4 padOut", padOut0, eOut);
      check(mInRst ? "R1 analogSel" : "R2 analogSel", analogSel0, ~mMode);
      check(mInRst ? "R1 rdValid" : "R8 rdValid", {7'd0, rdValid0}, {7'd0, mRdV});
      if (mRdV) check({mRdTag, " rdData"}, rdData0, mRd);
      check("R7 padOe narrow", {4'd0, padOe1}, {4'd0, eOe[3:0]});
      check("R7 padOut narrow", {4'd0, padOut1}, {4'd0, eOut[3:0]});
      check("R7 analogSel narrow", {4'd0, analogSel1}, {4'd0, ~mMode[3:0]});
      if (mRdV) check("R7 rdData narrow", rdData1, mRd & 8'h0F);
    end
  end

  task automatic busOp(bit w, logic [1:0] wa, logic [7:0] wd, bit r, logic [1:0] ra);
    @(negedge clk);
    wrEn = w; wrAddr = wa; wrData = wd; rdEn = r; rdAddr = ra;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) busOp(0, 2'd0, 8'h00, 0, 2'd0);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    @(posedge clk);
    started = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset contents read back
    busOp(0, 2'd0, 8'h00, 1, 2'd0);
    busOp(0, 2'd0, 8'h00, 1, 2'd1);
    busOp(0, 2'd0, 8'h00, 1, 2'd2);
    idle(1);
    // R9: program while analog, nothing drives
    busOp(1, 2'd1, 8'h00, 0, 2'd0);
    busOp(1, 2'd2, 8'hA5, 0, 2'd0);
    idle(1);
    check("R9 no drive while analog", padOe0, 8'h00);
    busOp(1, 2'd0, 8'hFF, 0, 2'd0);
    idle(1);
    check("R9 level applied on switch", padOut0, 8'hA5);
    // R5: readback follows pins, not written data
    @(negedge clk) padIn = 8'h3C;
    idle(3);
    busOp(0, 2'd0, 8'h00, 1, 2'd2);
    idle(1);
    check("R5 pin readback", rdData0, 8'h3C);
    // R2: upper half analog
    busOp(1, 2'd0, 8'h0F, 0, 2'd0);
    busOp(0, 2'd0, 8'h00, 1, 2'd2);
    busOp(1, 2'd1, 8'hF0, 0, 2'd0);
    idle(1);
    // R8: same-cycle write and read
    busOp(1, 2'd2, 8'h5A, 1, 2'd2);
    busOp(1, 2'd0, 8'hC3, 1, 2'd0);
    busOp(1, 2'd1, 8'h18, 1, 2'd1);
    idle(1);
    // R6: empty slot
    busOp(1, 2'd3, 8'hFF, 1, 2'd3);
    busOp(0, 2'd0, 8'h00, 1, 2'd3);
    busOp(0, 2'd0, 8'h00, 1, 2'd0);
    busOp(0, 2'd0, 8'h00, 1, 2'd1);
    idle(1);
    // random traffic with pad changes in the same cycles
    for (int k = 0; k < 400; k++) begin
      busOp($urandom_range(0, 1), 2'($urandom), 8'($urandom),
            $urandom_range(0, 1), 2'($urandom));
      padIn = 8'($urandom);
    end
    idle(2);
    // R1: reset in mid-run
    @(negedge clk); #1 rstN = 1'b0;
    idle(3);
    @(negedge clk); rstN = 1'b1;
    busOp(0, 2'd0, 8'h00, 1, 2'd1);
    idle(2);
    summary();
  end
endmodule